// File: doc/BRIEF.md
# Data Link Zero-Destuffing Receiver

This block sits on the receive side of a serial facility data link. One bit arrives with each strobe of `bit_en_i`. When zero removal is switched on, the block drops any zero that comes right after a run of exactly five ones, which undoes the bit stuffing a sender adds so that data never looks like a flag (`01111110`) or an abort (`11111111`). A zero that ends a run of six or more ones is real line content and is kept.

The bits that survive are packed into bytes, least significant bit first. Each finished byte is placed in a holding register and announced by a one-clock ready pulse. The block then compares the byte against two programmable match bytes. A hit on either one sets a sticky flag. The interrupt follows that flag when its mask bit is set. Software uses a small write/read register port to set the enable, the match bytes and the mask, and to clear the flag.

Top module: `dl_destuff_rx`

## Requirements
- R1: With zero removal disabled (control register, address 0, bit 0 = 0), every strobed bit is shifted into the byte, including zeros that follow five ones.
- R2: With zero removal enabled (address 0 bit 0 = 1), a zero strobed directly after exactly five consecutive ones is discarded and is not counted toward the byte.
- R3: With zero removal enabled, a zero that follows six or more consecutive ones is kept. So the flag pattern and eight ones are assembled unchanged.
- R4: Kept bits fill the byte least significant bit first: the first kept bit of a byte lands in bit 0 and the eighth kept bit lands in bit 7.
- R5: `byte_rdy_o` is high for exactly one clock after the edge that takes in the eighth kept bit. `rx_byte_o` changes on that same edge and holds its value until the next byte completes.
- R6: When a completed byte equals match byte A (address 1) or match byte B (address 2), status bit 0 (address 3) reads 1 from the clock after `byte_rdy_o`.
- R7: The status flag stays set until a write to address 3 with data bit 0 = 1 clears it. A write to that address with bit 0 = 0 leaves it unchanged.
- R8: `irq_o` is high exactly when the status flag and the mask bit (address 0, bit 1) are both 1.
- R9: Reset clears the run count, the bit position, the receive byte, the status flag, the mask and the enable. After reset, a full byte is assembled from the first bit onward.
- R10: Reads return control at address 0 (bit 1 mask, bit 0 enable), match A at address 1, match B at address 2, status at address 3 and the receive byte at address 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Strobe: `bit_i` is valid this cycle |
| bit_i | input | 1 | Serial data bit |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| rx_byte_o | output | 8 | Last completed byte |
| byte_rdy_o | output | 1 | One-clock pulse on byte completion |
| irq_o | output | 1 | Match interrupt |

## Verification
The bench targets the boundary between a run of five ones and a run of six. If the run count were off by one, the zero after a flag's six ones would be dropped, or a stuffed zero would be kept, and the assembled byte would be wrong. Streams with stuffed zeros are nine bits long, so a design that counted the dropped bit would complete the byte one strobe early, with a shifted value. Other stimulus covers sticky clearing with data bit 0 equal to 0 and to 1, interrupt masking in both directions, and a reset in the middle of a byte. A design that did not clear the bit position on reset would assemble the next byte misaligned.

// File: rtl/dl_rx_pkg.sv
package dl_rx_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned STUFF_RUN = 5;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MATCHA = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MATCHB = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RXBYTE = 3'd4;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MASK_BIT = 1;
endpackage

// File: rtl/dl_zero_destuff.sv
module dl_zero_destuff #(
  parameter int unsigned RUN_LIMIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic kept_vld_o,
  output logic kept_bit_o
);
  localparam int unsigned RUN_SAT = RUN_LIMIT + 1;
  localparam int unsigned RUN_W   = $clog2(RUN_SAT + 1);

  logic [RUN_W-1:0] run_q;
  logic             drop;

  assign drop       = bit_en_i && !bit_i && en_i && (run_q == RUN_W'(RUN_LIMIT));
  assign kept_vld_o = bit_en_i && !drop;
  assign kept_bit_o = bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (bit_en_i) begin
      if (!bit_i)                          run_q <= '0;
      else if (run_q != RUN_W'(RUN_SAT))   run_q <= run_q + 1'b1;
    end
  end

  // R3
  run_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(RUN_SAT));

  // R2
  zero_clears_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !bit_i) |=> (run_q == '0));
endmodule

// File: rtl/dl_byte_asm.sv
module dl_byte_asm #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              rdy_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] sr_nxt;
  logic [CNT_W-1:0]  cnt_q;

  // LSB first: new bit enters at the top and moves down
  assign sr_nxt = {bit_i, sr_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      byte_o <= '0;
      rdy_o  <= 1'b0;
    end else begin
      rdy_o <= 1'b0;
      if (vld_i) begin
        sr_q <= sr_nxt;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          byte_o <= sr_nxt;
          rdy_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5
  rdy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);

  // R5
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> $stable(byte_o));
endmodule

// File: rtl/dl_match_det.sv
module dl_match_det #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] match_a_i,
  input  logic [DATA_W-1:0] match_b_i,
  input  logic              clr_i,
  output logic              hit_o
);
  logic [1:0] eq;

  assign eq[0] = (byte_i == match_a_i);
  assign eq[1] = (byte_i == match_b_i);

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hit_o <= 1'b0;
    else if (rdy_i && |eq)   hit_o <= 1'b1;
    else if (clr_i)          hit_o <= 1'b0;
  end

  // R6
  match_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i && (byte_i == match_a_i || byte_i == match_b_i)) |=> hit_o);

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !clr_i) |=> hit_o);
endmodule

// File: rtl/dl_destuff_rx.sv
module dl_destuff_rx
  import dl_rx_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = STUFF_RUN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              byte_rdy_o,
  output logic              irq_o
);
  logic              en_q, mask_q;
  logic [DATA_W-1:0] match_a_q, match_b_q;
  logic              kept_vld, kept_bit;
  logic              hit;
  logic              stat_clr;

  assign stat_clr = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      mask_q    <= 1'b0;
      match_a_q <= '0;
      match_b_q <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        ADDR_CTRL: begin
          en_q   <= reg_wdata_i[CTRL_EN_BIT];
          mask_q <= reg_wdata_i[CTRL_MASK_BIT];
        end
        ADDR_MATCHA: match_a_q <= reg_wdata_i;
        ADDR_MATCHB: match_b_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[CTRL_EN_BIT]   = en_q;
        reg_rdata_o[CTRL_MASK_BIT] = mask_q;
      end
      ADDR_MATCHA: reg_rdata_o = match_a_q;
      ADDR_MATCHB: reg_rdata_o = match_b_q;
      ADDR_STAT:   reg_rdata_o[0] = hit;
      ADDR_RXBYTE: reg_rdata_o = rx_byte_o;
      default: ;
    endcase
  end

  dl_zero_destuff #(.RUN_LIMIT(RUN_LIMIT)) u_destuff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .bit_en_i  (bit_en_i),
    .bit_i     (bit_i),
    .kept_vld_o(kept_vld),
    .kept_bit_o(kept_bit)
  );

  dl_byte_asm #(.DATA_W(DATA_W)) u_asm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (kept_vld),
    .bit_i (kept_bit),
    .byte_o(rx_byte_o),
    .rdy_o (byte_rdy_o)
  );

  dl_match_det #(.DATA_W(DATA_W)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rdy_i    (byte_rdy_o),
    .byte_i   (rx_byte_o),
    .match_a_i(match_a_q),
    .match_b_i(match_b_q),
    .clr_i    (stat_clr),
    .hit_o    (hit)
  );

  assign irq_o = hit && mask_q;

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q && hit));

  // R1
  pass_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && bit_en_i) |-> kept_vld);
endmodule

// File: tb/dl_destuff_rx_tb.sv
`timescale 1ns/1ps
module dl_destuff_rx_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o, rx_byte_o;
  logic       byte_rdy_o, irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  dl_destuff_rx u_dut (.*);

  localparam int NV = 9;
  localparam logic       V_EN  [NV] = '{0, 1, 1, 1, 1, 0, 1, 1, 1};
  localparam int         V_LEN [NV] = '{8, 8, 9, 8, 8, 8, 9, 8, 8};
  localparam logic [15:0] V_STR[NV] = '{16'h025, 16'h03C, 16'h0DF, 16'h03F, 16'h07E,
                                        16'h05F, 16'h03E, 16'h0FF, 16'h040};
  localparam logic [7:0] V_EXP [NV] = '{8'h25, 8'h3C, 8'h7F, 8'h3F, 8'h7E,
                                        8'h5F, 8'h3E, 8'hFF, 8'h40};
  localparam logic       V_HIT [NV] = '{0, 0, 0, 1, 1, 0, 0, 0, 0};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic send(input logic [15:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      bit_en_i = 1'b1; bit_i = s[i];
    end
    @(negedge clk_i);
    bit_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_err);
    $finish;
  end

  initial begin
    logic [7:0] r;
    idle(2);
    // R9 reset state
    check("R9 rx_byte", rx_byte_o, 8'h00);
    check("R9 byte_rdy", {7'd0, byte_rdy_o}, 8'h00);
    check("R9 irq", {7'd0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    idle(1);
    rd(3'd0, r); check("R9 ctrl", r, 8'h00);
    rd(3'd3, r); check("R9 status", r, 8'h00);

    wr(3'd1, 8'h3F);
    wr(3'd2, 8'h7E);
    // R10 read-back
    rd(3'd1, r); check("R10 matchA", r, 8'h3F);
    rd(3'd2, r); check("R10 matchB", r, 8'h7E);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, {7'd0, V_EN[v]});
      wr(3'd3, 8'h01);
      send(V_STR[v], V_LEN[v] - 1);
      check($sformatf("R2/R3 v%0d early rdy", v), {7'd0, byte_rdy_o}, 8'h00);
      send(V_STR[v] >> (V_LEN[v] - 1), 1);
      check($sformatf("R5 v%0d rdy", v), {7'd0, byte_rdy_o}, 8'h01);
      check($sformatf("R1/R2/R3/R4 v%0d byte", v), rx_byte_o, V_EXP[v]);
      idle(1);
      check($sformatf("R5 v%0d rdy drop", v), {7'd0, byte_rdy_o}, 8'h00);
      rd(3'd3, r); check($sformatf("R6 v%0d status", v), r, {7'd0, V_HIT[v]});
    end

    // R8 mask on: match raises irq
    wr(3'd0, 8'h03);
    rd(3'd0, r); check("R10 ctrl", r, 8'h03);
    wr(3'd3, 8'h01);
    send(16'h03F, 8);
    idle(1);
    check("R8 irq masked-in", {7'd0, irq_o}, 8'h01);
    // R7 write 0 keeps flag
    wr(3'd3, 8'h00);
    rd(3'd3, r); check("R7 keep on zero write", r, 8'h01);
    wr(3'd3, 8'h01);
    rd(3'd3, r); check("R7 cleared", r, 8'h00);
    check("R8 irq after clear", {7'd0, irq_o}, 8'h00);

    // R8 mask off: flag set, irq low
    wr(3'd0, 8'h01);
    send(16'h07E, 8);
    idle(1);
    rd(3'd3, r); check("R6 matchB status", r, 8'h01);
    check("R8 irq masked-out", {7'd0, irq_o}, 8'h00);
    // R5 hold
    idle(5);
    check("R5 hold", rx_byte_o, 8'h7E);
    rd(3'd4, r); check("R10 rxbyte reg", r, 8'h7E);

    // R9 reset mid-byte
    send(16'h007, 3);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 rx cleared", rx_byte_o, 8'h00);
    check("R9 irq cleared", {7'd0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    rd(3'd3, r); check("R9 status cleared", r, 8'h00);
    rd(3'd0, r); check("R9 ctrl cleared", r, 8'h00);
    send(16'h0A5, 8);
    check("R9 realigned byte", rx_byte_o, 8'hA5);
    check("R9 realigned rdy", {7'd0, byte_rdy_o}, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule